// File: doc/BRIEF.md
# Comma Detect Word Aligner

This block sits behind a deserializer that delivers 10-bit words on an arbitrary bit boundary. It watches the bit stream for the positive-disparity 8B/10B comma and moves the word boundary so the comma starts an output word. It then presents framed words together with a flag that marks comma words. Bit 0 of every input and output word is the bit received first.

A detect-enable input selects the operating mode. When it is high, the block is framed and can realign at any bit position. When it is low, the block is unframed and words keep the boundary already in force.

A rate input selects between two strobe modes. In full-rate mode the block drives two complementary strobes at half the word rate, and shifts the data phase so that a comma always lands while the second strobe is high. In half-rate mode the second strobe is simply high on every word and no phase shift is applied. The shift is made by slipping one word: either a word is repeated or a non-comma word is dropped. The strobes themselves never pause.

Top module: `comma_word_aligner`

## Requirements
- R1: A comma is a 10-bit word whose bits 0 and 1 are 0 and whose bits 2 to 6 are 1, with bits 7 to 9 don't-care. No other bit pattern causes realignment.
- R2: The search window is the previous input word (window bits 0 to 9) followed by the current input word (window bits 10 to 19). If det_en is high and a comma starts at offset o (0 to 9) of the previous word, the boundary becomes o. The lowest such offset wins. The framed word is window bits o to o+9. It appears on word_out after the edge that follows the edge sampling the current word, and that word already uses the new boundary.
- R3: While det_en is sampled low, the boundary does not change, whatever the input contains.
- R4: comma_flag is high exactly when word_out is a comma word and det_en was high on the edge that sampled the later word of its window. Otherwise it is low.
- R5: A change of det_en reaches comma_flag within two edges, which is less than 3 word times.
- R6: Commas arriving in consecutive words each raise comma_flag, so the flag stays high across the run. No enabled comma is skipped.
- R7: In full-rate mode (full_rate=1), strb_a is the complement of strb_b, and strb_b toggles on every clock edge without exception.
- R8: In full-rate mode, a flagged comma word that follows an unflagged word is presented while strb_b is 1.
- R9: In full-rate mode, the number of flagged words equals the number of enabled commas in the stream. The phase shift only repeats or drops unflagged words.
- R10: In half-rate mode (full_rate=0), strb_b is 1 and strb_a is 0 on every cycle. Data follows the fixed latency of R2 with no slip.
- R11: During reset, word_out is 0, comma_flag is 0 and the boundary is 0. The full-rate strobe phase is strb_b=0 and strb_a=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_word | input | 10 | Deserialized word on an arbitrary boundary, bit 0 received first |
| det_en | input | 1 | 1 selects framed operation (realign on comma), 0 selects unframed pass-through |
| full_rate | input | 1 | 1 selects the complementary half-word-rate strobes, 0 selects the word-rate strobe |
| word_out | output | 10 | Framed output word |
| comma_flag | output | 1 | Output word is an enabled comma |
| strb_a | output | 1 | First strobe (complement of strb_b in full-rate mode, 0 otherwise) |
| strb_b | output | 1 | Second strobe; commas are presented while it is high |

## Verification
In full-rate mode, the phase correction and the back-to-back comma rule can fall on the same cycle: a second comma arrives exactly when the strobe phase is wrong for it. The bench provokes this by forcing commas at the same offset in several consecutive words while full_rate is high. It judges the result in three ways. Every flagged word must be counted. The strobes must keep toggling. Only a comma that follows an unflagged word is held to the strb_b phase rule.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;
  localparam int CW_W     = 10;
  localparam int CW_PAT_W = 7;
  localparam int CW_WIN_W = 2 * CW_W;
  localparam int CW_OFF_W = $clog2(CW_W);
  // bit 0 is received first: 0,0,1,1,1,1,1
  localparam logic [CW_PAT_W-1:0] CW_PAT = 7'b1111100;

  function automatic logic cw_is_comma(input logic [CW_W-1:0] w);
    return w[CW_PAT_W-1:0] == CW_PAT;
  endfunction

  function automatic logic [CW_W-1:0] cw_extract(input logic [CW_WIN_W-1:0] win,
                                                 input logic [CW_OFF_W-1:0] off);
    logic [CW_WIN_W-1:0] sh;
    sh = win >> off;
    return sh[CW_W-1:0];
  endfunction
endpackage

// File: rtl/cw_search.sv
module cw_search
  import comma_align_pkg::*;
(
  input  logic [CW_WIN_W-1:0] win,
  output logic                hit,
  output logic [CW_OFF_W-1:0] hit_off
);
  logic [CW_W-1:0] match_vec;

  for (genvar k = 0; k < CW_W; k++) begin : g_tap
    assign match_vec[k] = cw_is_comma(win[k +: CW_W]);
  end

  assign hit = |match_vec;

  // lowest offset has priority
  always_comb begin
    hit_off = '0;
    for (int k = CW_W - 1; k >= 0; k--) begin
      if (match_vec[k]) hit_off = CW_OFF_W'(k);
    end
  end
endmodule

// File: rtl/cw_align.sv
module cw_align
  import comma_align_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] rx_word,
  input  logic            det_en,
  output logic [CW_W-1:0] al_word,
  output logic            al_en
);
  logic [CW_W-1:0]     prev_q;
  logic [CW_OFF_W-1:0] shift_q;
  logic [CW_WIN_W-1:0] win;
  logic                hit;
  logic [CW_OFF_W-1:0] hit_off;
  logic                realign_evt;
  logic [CW_OFF_W-1:0] use_off;

  assign win = {rx_word, prev_q};

  cw_search u_search (
    .win     (win),
    .hit     (hit),
    .hit_off (hit_off)
  );

  assign realign_evt = det_en && hit;
  assign use_off     = realign_evt ? hit_off : shift_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= '0;
      shift_q <= '0;
      al_word <= '0;
      al_en   <= 1'b0;
    end else begin
      prev_q  <= rx_word;
      if (realign_evt) shift_q <= hit_off;
      al_word <= cw_extract(win, use_off);
      al_en   <= det_en;
    end
  end

  // R1: a realignment always frames a word holding the comma pattern
  assert_pattern_R1: assert property (@(posedge clk) disable iff (!rst_n)
    realign_evt |=> (al_word[1:0] == 2'b00 && al_word[6:2] == 5'b11111));

  // R3: boundary frozen while detection is off
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !det_en |=> $stable(shift_q));
endmodule

// File: rtl/cw_phase_out.sv
module cw_phase_out
  import comma_align_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            full_rate,
  input  logic [CW_W-1:0] al_word,
  input  logic            al_en,
  output logic [CW_W-1:0] word_out,
  output logic            comma_flag,
  output logic            strb_a,
  output logic            strb_b
);
  logic [CW_W-1:0] dl_q;
  logic            den_q;
  logic            sel_q;   // 1: output taken from the one-word delay tap
  logic            ph_q;
  logic            ph_n;
  logic            sel_n;
  logic            lead_sw; // delay tap -> direct, drops one unflagged word
  logic            lag_sw;  // direct -> delay tap, repeats one unflagged word
  logic            cur_comma;
  logic            dl_comma;
  logic [CW_W-1:0] pick_w;
  logic            pick_en;

  assign ph_n      = ~ph_q;
  assign cur_comma = al_en && cw_is_comma(al_word);
  assign dl_comma  = den_q && cw_is_comma(dl_q);
  assign lead_sw   = sel_q && cur_comma && !dl_comma && ph_n;
  assign lag_sw    = !sel_q && cur_comma && !comma_flag && !ph_n;

  always_comb begin
    if (!full_rate)   sel_n = 1'b0;
    else if (lead_sw) sel_n = 1'b0;
    else if (lag_sw)  sel_n = 1'b1;
    else              sel_n = sel_q;
    pick_w  = sel_n ? dl_q  : al_word;
    pick_en = sel_n ? den_q : al_en;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl_q       <= '0;
      den_q      <= 1'b0;
      sel_q      <= 1'b0;
      ph_q       <= 1'b0;
      word_out   <= '0;
      comma_flag <= 1'b0;
    end else begin
      dl_q       <= al_word;
      den_q      <= al_en;
      sel_q      <= sel_n;
      ph_q       <= ph_n;
      word_out   <= pick_w;
      comma_flag <= pick_en && cw_is_comma(pick_w);
    end
  end

  assign strb_b = full_rate ? ph_q  : 1'b1;
  assign strb_a = full_rate ? ~ph_q : 1'b0;

  // R4: flag only ever marks a comma word
  assert_flag_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    comma_flag |-> (word_out[1:0] == 2'b00 && word_out[6:2] == 5'b11111));

  // R7: strobes never stall in full-rate mode
  assert_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && full_rate && $past(full_rate)) |-> (strb_b != $past(strb_b)));

  // R8: first comma of a run sits on the second strobe
  assert_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && full_rate && $past(full_rate) && comma_flag && !$past(comma_flag))
      |-> strb_b);

  // R10: half-rate mode always uses the direct path
  assert_half_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !full_rate |=> !sel_q);
endmodule

// File: rtl/comma_word_aligner.sv
module comma_word_aligner
  import comma_align_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CW_W-1:0] rx_word,
  input  logic            det_en,
  input  logic            full_rate,
  output logic [CW_W-1:0] word_out,
  output logic            comma_flag,
  output logic            strb_a,
  output logic            strb_b
);
  logic [CW_W-1:0] al_word;
  logic            al_en;

  cw_align u_align (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_word (rx_word),
    .det_en  (det_en),
    .al_word (al_word),
    .al_en   (al_en)
  );

  cw_phase_out u_phase (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_rate  (full_rate),
    .al_word    (al_word),
    .al_en      (al_en),
    .word_out   (word_out),
    .comma_flag (comma_flag),
    .strb_a     (strb_a),
    .strb_b     (strb_b)
  );
endmodule

// File: tb/test_comma_word_aligner.sv
`timescale 1ns/1ps
module test_comma_word_aligner;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [9:0] rx_word;
  logic       det_en;
  logic       full_rate;
  logic [9:0] word_out;
  logic       comma_flag;
  logic       strb_a;
  logic       strb_b;

  always #2.5 clk = ~clk;

  comma_word_aligner i_comma_word_aligner (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .det_en(det_en),
    .full_rate(full_rate), .word_out(word_out), .comma_flag(comma_flag),
    .strb_a(strb_a), .strb_b(strb_b)
  );

  int checks = 0;
  int errors = 0;
  logic [9:0] wh [8];
  logic       eh [8];
  int         ch [8];
  int   kk = 0;
  int   exp_off = 0;
  logic [9:0] pend = '0;
  int   pend_cnt = 0;
  int   run1 = 0;
  bit   cur_en = 1'b1;
  bit   chk_half = 1'b0;
  bit   chk_full = 1'b0;
  string tag_w = "R2";
  string tag_f = "R4";
  logic prev_b = 1'b0;
  logic prev_f = 1'b0;
  int   exp_commas = 0;
  int   seen_commas = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] frame_at(input logic [9:0] older, input logic [9:0] newer,
                                          input int off);
    logic [19:0] bits;
    bits = {newer, older};
    return bits[off +: 10];
  endfunction

  // builds a word bit by bit; filler never holds five ones in a row
  task automatic gen_word(input int pct, input int force_off,
                          output logic [9:0] w, output int cs);
    cs = -1;
    if (force_off >= 0) begin
      if (force_off >= pend_cnt) cs = force_off;
    end else if (pend_cnt < 10 && int'($urandom % 100) < pct) begin
      cs = pend_cnt + int'($urandom % (10 - pend_cnt));
    end
    for (int b = 0; b < 10; b++) begin
      logic bitv;
      if (b == cs) begin
        pend = {3'($urandom), 7'b1111100};
        pend_cnt = 10;
      end
      if (pend_cnt > 0) begin
        bitv = pend[0];
        pend = pend >> 1;
        pend_cnt--;
      end else begin
        bitv = (run1 >= 4) ? 1'b0 : 1'($urandom);
      end
      run1 = bitv ? run1 + 1 : 0;
      w[b] = bitv;
    end
  endtask

  task automatic do_check();
    int j;
    logic [9:0] ew;
    logic ef;
    j = kk - 3;
    if (j >= 0) begin
      if (ch[j % 8] >= 0 && eh[(j + 1) % 8]) exp_off = ch[j % 8];
      ew = frame_at(wh[j % 8], wh[(j + 1) % 8], exp_off);
      ef = eh[(j + 1) % 8] && (ch[j % 8] == exp_off);
      if (chk_half) begin
        chk(tag_w, "framed word", int'(word_out), int'(ew));
        chk(tag_f, "comma flag", int'(comma_flag), int'(ef));
        chk("R10", "strb_b high", int'(strb_b), 1);
        chk("R10", "strb_a low", int'(strb_a), 0);
      end
      if (chk_full) begin
        if (ef) exp_commas++;
        if (comma_flag) seen_commas++;
        chk("R7", "strobe complement", int'(strb_a), int'(!strb_b));
        chk("R7", "strobe toggles", int'(strb_b), int'(!prev_b));
        if (comma_flag && !prev_f) chk("R8", "comma on strb_b", int'(strb_b), 1);
      end
    end
    prev_b = strb_b;
    prev_f = comma_flag;
  endtask

  // en_mode: 0 on, 1 random toggling, 2 off
  task automatic run_words(input int n, input int pct, input int en_mode, input int force_off);
    for (int i = 0; i < n; i++) begin
      logic [9:0] w;
      int cs;
      do_check();
      gen_word(pct, force_off, w, cs);
      if (en_mode == 0) cur_en = 1'b1;
      else if (en_mode == 2) cur_en = 1'b0;
      else if (($urandom % 100) < 30) cur_en = !cur_en;
      rx_word = w;
      det_en  = cur_en;
      wh[kk % 8] = w;
      eh[kk % 8] = cur_en;
      ch[kk % 8] = cs;
      kk++;
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; rx_word = '0; det_en = 1'b0; full_rate = 1'b1;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "word_out in reset", int'(word_out), 0);
    chk("R11", "flag in reset", int'(comma_flag), 0);
    chk("R11", "strb_b in reset", int'(strb_b), 0);
    chk("R11", "strb_a in reset", int'(strb_a), 1);
    full_rate = 1'b0;
    #0.1;
    chk("R10", "half-rate strb_b in reset", int'(strb_b), 1);
    @(negedge clk);
    rst_n = 1'b1;
    chk_half = 1'b1;
    // R2 / R4: framed, random commas
    tag_w = "R2"; tag_f = "R4";
    run_words(1500, 25, 0, -1);
    // R1: directed offsets 0..9, separated by filler
    tag_w = "R1";
    for (int o = 0; o < 10; o++) begin
      run_words(3, 0, 0, -1);
      run_words(1, 0, 0, o);
      run_words(3, 0, 0, -1);
    end
    // R3: detection off, commas at new offsets are ignored
    tag_w = "R3";
    run_words(2, 0, 0, -1);
    run_words(1, 0, 0, 7);
    run_words(4, 0, 0, -1);
    run_words(1, 0, 2, 2);
    run_words(6, 30, 2, -1);
    // R5: detect enable toggling under traffic
    tag_f = "R5";
    run_words(1500, 30, 1, -1);
    // R6: back-to-back commas at one offset
    tag_w = "R2"; tag_f = "R6";
    run_words(4, 0, 0, -1);
    run_words(6, 0, 0, 3);
    run_words(4, 0, 0, -1);
    run_words(6, 0, 0, 0);
    run_words(4, 0, 0, -1);
    // full-rate mode
    chk_half = 1'b0;
    full_rate = 1'b1;
    run_words(8, 0, 0, -1);
    chk_full = 1'b1;
    run_words(1500, 25, 0, -1);
    for (int r = 0; r < 20; r++) begin
      run_words(3, 0, 0, -1);
      run_words(2 + r % 4, 0, 0, (r * 3) % 10 == 9 ? 9 : (r * 3) % 10);
    end
    run_words(400, 30, 1, -1);
    run_words(10, 0, 0, -1);
    chk("R9", "flagged commas in full-rate", seen_commas, exp_commas);
    chk("R6", "commas seen in full-rate", int'(seen_commas > 0), 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule